// File: doc/BRIEF.md
# FIFO Level Interrupt Status Unit

This block maintains the interrupt status word of a serial-peripheral controller. It watches the occupancy counts of the transmit and receive FIFOs and turns them into level flags: not empty, quarter, half, three-quarter and full on the receive side, and empty, free-space and low-fill flags on the transmit side. Next to these it holds sticky event flags for transfer completion, chip-select events and FIFO overflow and underflow. Software clears them by writing ones to the status word.

The block also holds an interrupt enable word. It drives a single interrupt line, which is high while any enabled status bit is set. A pulse on either FIFO's clear input loads a known state into that FIFO's flags for one cycle. After that, the level flags again follow the live counts. The FIFOs, the shift engine and the software bus decoding sit outside the block. They reach it through count inputs, one-cycle event pulses and write strobes that share one data bus.

Top module: `lvl_irq_status`

## Requirements
- R1: After reset, `status` reads 0x00001B00, `enable` reads 0 and `irq` is low.
- R2: With a depth of 64, the receive flags, registered one cycle after the count, are set as follows. Bit 0 is set when the used count is nonzero. Bit 3 is set when used is 16 or more. Bit 1 is set when used is 32 or more. Bit 4 is set when free space (64 minus used) is 16 or less. Bit 2 is set when used equals 64.
- R3: With a depth of 64, the transmit flags, registered one cycle after the count, are set as follows. Bit 8 is set when used is 0. Bit 11 is set when free space is 16 or more. Bit 9 is set when free space is 32 or more. Bit 12 is set when used is 16 or less. Bit 10 is set when used equals 64.
- R4: The level flags (bits 0–4 and 8–12) are recomputed from the counts on every cycle. A write-one-to-clear to them leaves them unchanged in the following cycle.
- R5: Each event pulse sets its sticky bit on the next cycle, and the bit stays set with no further pulses. The pulses map as follows: done to bit 16, chip-select to bit 17, transmit overflow to bit 13, transmit underflow to bit 14, receive overflow to bit 5 and receive underflow to bit 6.
- R6: A `sts_wr` strobe clears every sticky bit (5, 6, 13, 14, 16, 17) whose `wr_data` bit is one. A set pulse in the same cycle wins over the clear.
- R7: Bit 31 is set by `cnt_err_pulse` and is never cleared by a status write. Only reset clears it.
- R8: A `tx_fifo_clr` pulse makes the next status show bits 8, 9, 11 and 12 set and bits 10, 13 and 14 clear. It overrides the counts and the event pulses of that cycle.
- R9: An `rx_fifo_clr` pulse makes the next status show bits 0 to 6 all clear. It overrides the counts and the event pulses of that cycle.
- R10: An `en_wr` strobe loads `enable` with `wr_data` AND 0x00037F7F.
- R11: `irq` is high exactly when `status` AND `enable` is nonzero. Bit 31 alone never raises it.
- R12: Status bits outside the mask 0x80037F7F always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_used | input | CW | Transmit FIFO entries in use |
| rx_used | input | CW | Receive FIFO entries in use |
| done_pulse | input | 1 | Transfer finished event |
| ss_pulse | input | 1 | Chip-select event |
| tx_ovf_pulse | input | 1 | Transmit FIFO overflow event |
| tx_udf_pulse | input | 1 | Transmit FIFO underflow event |
| rx_ovf_pulse | input | 1 | Receive FIFO overflow event |
| rx_udf_pulse | input | 1 | Receive FIFO underflow event |
| cnt_err_pulse | input | 1 | Burst-count error event (bit 31) |
| tx_fifo_clr | input | 1 | Transmit FIFO cleared this cycle |
| rx_fifo_clr | input | 1 | Receive FIFO cleared this cycle |
| sts_wr | input | 1 | Write-one-to-clear strobe for the status word |
| en_wr | input | 1 | Write strobe for the enable word |
| wr_data | input | 32 | Write data shared by both strobes |
| status | output | 32 | Interrupt status word |
| enable | output | 32 | Interrupt enable word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default depth of 64, so the count width is 7. The quarter and half thresholds therefore land at 16 and 32, and the full count of 64 is reachable. This lets the count sweeps place values just below, on and just above every threshold on both sides, including the full and empty extremes. It also lets a FIFO clear be issued while the counts still show a full FIFO, so the one-cycle preload shows up distinctly against the live value.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    localparam int unsigned STS_W = 32;

    // receive level flags
    localparam int unsigned B_RX_RDY  = 0;
    localparam int unsigned B_RX_HALF = 1;
    localparam int unsigned B_RX_FULL = 2;
    localparam int unsigned B_RX_Q1   = 3;
    localparam int unsigned B_RX_Q3   = 4;
    // receive sticky flags
    localparam int unsigned B_RX_OVF  = 5;
    localparam int unsigned B_RX_UDF  = 6;
    // transmit level flags
    localparam int unsigned B_TX_EMPTY = 8;
    localparam int unsigned B_TX_HALF  = 9;
    localparam int unsigned B_TX_FULL  = 10;
    localparam int unsigned B_TX_Q1    = 11;
    localparam int unsigned B_TX_Q3    = 12;
    // transmit sticky flags
    localparam int unsigned B_TX_OVF  = 13;
    localparam int unsigned B_TX_UDF  = 14;
    // engine sticky flags
    localparam int unsigned B_DONE    = 16;
    localparam int unsigned B_SS      = 17;
    localparam int unsigned B_CNT_ERR = 31;

    localparam int unsigned RX_LVL_LO = B_RX_RDY;
    localparam int unsigned TX_LVL_LO = B_TX_EMPTY;
    localparam int unsigned LVL_N     = 5;

    localparam logic [STS_W-1:0] STS_MASK    = 32'h8003_7F7F;
    localparam logic [STS_W-1:0] W1C_MASK    = STS_MASK & ~(32'h1 << B_CNT_ERR);
    localparam logic [STS_W-1:0] EN_MASK     = 32'h0003_7F7F;
    localparam logic [STS_W-1:0] STICKY_MASK = 32'h8003_6060;

    // transmit level flags after a FIFO clear: [Q3,Q1,FULL,HALF,EMPTY]
    localparam logic [LVL_N-1:0] TX_LVL_CLR = 5'b11011;
    localparam logic [LVL_N-1:0] RX_LVL_CLR = 5'b00000;
endpackage

// File: rtl/lvl_irq_thresh.sv
module lvl_irq_thresh
    import lvl_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = $clog2(DEPTH + 1),
    parameter bit          IS_TX = 1'b0
) (
    input  logic [CW-1:0]    used,
    output logic [LVL_N-1:0] flags
);
    localparam logic [CW-1:0] QTR  = CW'(DEPTH / 4);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] free_sp;
    assign free_sp = FULL - used;

    generate
        if (IS_TX) begin : g_tx
            // [4]=used<=Q  [3]=free>=Q  [2]=full  [1]=free>=H  [0]=empty
            assign flags = {used <= QTR, free_sp >= QTR, used == FULL,
                            free_sp >= HALF, used == '0};
        end else begin : g_rx
            // [4]=free<=Q  [3]=used>=Q  [2]=full  [1]=used>=H  [0]=not empty
            assign flags = {free_sp <= QTR, used >= QTR, used == FULL,
                            used >= HALF, used != '0};
        end
    endgenerate
endmodule

// File: rtl/lvl_irq_levels.sv
module lvl_irq_levels
    import lvl_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    tx_used,
    input  logic [CW-1:0]    rx_used,
    input  logic             tx_clr,
    input  logic             rx_clr,
    output logic [LVL_N-1:0] tx_lvl,
    output logic [LVL_N-1:0] rx_lvl
);
    logic [LVL_N-1:0] tx_cmp, rx_cmp;

    lvl_irq_thresh #(.DEPTH(DEPTH), .CW(CW), .IS_TX(1'b1)) u_tx_thr (
        .used (tx_used),
        .flags(tx_cmp)
    );

    lvl_irq_thresh #(.DEPTH(DEPTH), .CW(CW), .IS_TX(1'b0)) u_rx_thr (
        .used (rx_used),
        .flags(rx_cmp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_lvl <= TX_LVL_CLR;
            rx_lvl <= RX_LVL_CLR;
        end else begin
            tx_lvl <= tx_clr ? TX_LVL_CLR : tx_cmp;
            rx_lvl <= rx_clr ? RX_LVL_CLR : rx_cmp;
        end
    end
endmodule

// File: rtl/lvl_irq_sticky.sv
module lvl_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic flush,
    output logic q
);
    // flush beats set, set beats a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (flush) q <= 1'b0;
        else if (set)   q <= 1'b1;
        else if (clr)   q <= 1'b0;
    end
endmodule

// File: rtl/lvl_irq_status.sv
module lvl_irq_status
    import lvl_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_used,
    input  logic [CW-1:0] rx_used,
    input  logic          done_pulse,
    input  logic          ss_pulse,
    input  logic          tx_ovf_pulse,
    input  logic          tx_udf_pulse,
    input  logic          rx_ovf_pulse,
    input  logic          rx_udf_pulse,
    input  logic          cnt_err_pulse,
    input  logic          tx_fifo_clr,
    input  logic          rx_fifo_clr,
    input  logic          sts_wr,
    input  logic          en_wr,
    input  logic [31:0]   wr_data,
    output logic [31:0]   status,
    output logic [31:0]   enable,
    output logic          irq
);
    logic [LVL_N-1:0] tx_lvl, rx_lvl;
    logic [STS_W-1:0] set_vec, flush_vec, clr_vec, sts_w;
    logic [STS_W-1:0] en_q;

    lvl_irq_levels #(.DEPTH(DEPTH), .CW(CW)) u_levels (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_used(tx_used),
        .rx_used(rx_used),
        .tx_clr (tx_fifo_clr),
        .rx_clr (rx_fifo_clr),
        .tx_lvl (tx_lvl),
        .rx_lvl (rx_lvl)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[B_RX_OVF]   = rx_ovf_pulse;
        set_vec[B_RX_UDF]   = rx_udf_pulse;
        set_vec[B_TX_OVF]   = tx_ovf_pulse;
        set_vec[B_TX_UDF]   = tx_udf_pulse;
        set_vec[B_DONE]     = done_pulse;
        set_vec[B_SS]       = ss_pulse;
        set_vec[B_CNT_ERR]  = cnt_err_pulse;

        flush_vec           = '0;
        flush_vec[B_RX_OVF] = rx_fifo_clr;
        flush_vec[B_RX_UDF] = rx_fifo_clr;
        flush_vec[B_TX_OVF] = tx_fifo_clr;
        flush_vec[B_TX_UDF] = tx_fifo_clr;

        clr_vec = sts_wr ? (wr_data & W1C_MASK) : '0;
    end

    generate
        for (genvar i = 0; i < STS_W; i++) begin : g_bit
            if (STICKY_MASK[i]) begin : g_sticky
                lvl_irq_sticky u_cell (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .set  (set_vec[i]),
                    .clr  (clr_vec[i]),
                    .flush(flush_vec[i]),
                    .q    (sts_w[i])
                );
            end else if (i >= RX_LVL_LO && i < RX_LVL_LO + LVL_N) begin : g_rx
                assign sts_w[i] = rx_lvl[i - RX_LVL_LO];
            end else if (i >= TX_LVL_LO && i < TX_LVL_LO + LVL_N) begin : g_tx
                assign sts_w[i] = tx_lvl[i - TX_LVL_LO];
            end else begin : g_zero
                assign sts_w[i] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wr_data & EN_MASK;
    end

    assign status = sts_w;
    assign enable = en_q;
    assign irq    = |(sts_w & en_q);
endmodule

// File: rtl/lvl_irq_status_chk.sv
module lvl_irq_status_chk #(
    parameter int unsigned CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] rx_used,
    input logic          done_pulse,
    input logic          rx_fifo_clr,
    input logic          tx_fifo_clr,
    input logic          en_wr,
    input logic [31:0]   wr_data,
    input logic [31:0]   status,
    input logic [31:0]   enable,
    input logic          irq
);
    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse && !rx_fifo_clr |=> status[16]);

    // R8
    tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_clr |=> (status[14:8] == 7'b0011011));

    // R9
    rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr |=> (status[6:0] == 7'b0));

    // R7
    cnt_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[31] |=> status[31]);

    // R2
    rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_used == '0) |=> !status[0]);

    // R10
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (enable == ($past(wr_data) & 32'h0003_7F7F)));

    // R11
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == 32'h0) |-> !irq);
endmodule

bind lvl_irq_status lvl_irq_status_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_used    (rx_used),
    .done_pulse (done_pulse),
    .rx_fifo_clr(rx_fifo_clr),
    .tx_fifo_clr(tx_fifo_clr),
    .en_wr      (en_wr),
    .wr_data    (wr_data),
    .status     (status),
    .enable     (enable),
    .irq        (irq)
);

// File: tb/lvl_irq_status_tb.sv
`timescale 1ns/1ps
module lvl_irq_status_tb;
    localparam int DEPTH = 64;
    localparam int CW    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] tx_used = '0, rx_used = '0;
    logic done_p = 0, ss_p = 0, txo_p = 0, txu_p = 0, rxo_p = 0, rxu_p = 0, ce_p = 0;
    logic tx_clr = 0, rx_clr = 0, sts_wr = 0, en_wr = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] status, enable;
    logic irq;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    string req = "R1";

    always #2 clk = ~clk;

    lvl_irq_status #(.DEPTH(DEPTH), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_used(tx_used), .rx_used(rx_used),
        .done_pulse(done_p), .ss_pulse(ss_p), .tx_ovf_pulse(txo_p),
        .tx_udf_pulse(txu_p), .rx_ovf_pulse(rxo_p), .rx_udf_pulse(rxu_p),
        .cnt_err_pulse(ce_p), .tx_fifo_clr(tx_clr), .rx_fifo_clr(rx_clr),
        .sts_wr(sts_wr), .en_wr(en_wr), .wr_data(wr_data),
        .status(status), .enable(enable), .irq(irq)
    );

    // behavioural reference
    logic [31:0] m_sts, m_en, nx;
    function automatic logic stick(logic cur, logic p, logic fl, logic c);
        if (fl) return 1'b0;
        if (p)  return 1'b1;
        if (c)  return 1'b0;
        return cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sts = 32'h0000_1B00;
            m_en  = 32'h0;
        end else begin
            int ru, tu;
            ru = int'(rx_used);
            tu = int'(tx_used);
            nx = 32'h0;
            nx[5]  = stick(m_sts[5],  rxo_p,  rx_clr, sts_wr && wr_data[5]);
            nx[6]  = stick(m_sts[6],  rxu_p,  rx_clr, sts_wr && wr_data[6]);
            nx[13] = stick(m_sts[13], txo_p,  tx_clr, sts_wr && wr_data[13]);
            nx[14] = stick(m_sts[14], txu_p,  tx_clr, sts_wr && wr_data[14]);
            nx[16] = stick(m_sts[16], done_p, 1'b0,   sts_wr && wr_data[16]);
            nx[17] = stick(m_sts[17], ss_p,   1'b0,   sts_wr && wr_data[17]);
            nx[31] = m_sts[31] | ce_p;
            if (!rx_clr) begin
                nx[0] = ru > 0;
                nx[3] = ru >= DEPTH / 4;
                nx[1] = ru >= DEPTH / 2;
                nx[4] = (DEPTH - ru) <= DEPTH / 4;
                nx[2] = ru == DEPTH;
            end
            if (tx_clr) begin
                nx[8] = 1; nx[9] = 1; nx[11] = 1; nx[12] = 1;
            end else begin
                nx[8]  = tu == 0;
                nx[11] = (DEPTH - tu) >= DEPTH / 4;
                nx[9]  = (DEPTH - tu) >= DEPTH / 2;
                nx[12] = tu <= DEPTH / 4;
                nx[10] = tu == DEPTH;
            end
            m_sts = nx;
            if (en_wr) m_en = wr_data & 32'h0003_7F7F;
        end
    end

    task automatic check_all();
        logic exp_irq;
        exp_irq = |(m_sts & m_en);
        vectors++;
        if (status !== m_sts || enable !== m_en || irq !== exp_irq) begin
            fails++;
            $display("FAIL %s status=%h/%h enable=%h/%h irq=%b/%b (actual/expected)",
                     req, status, m_sts, enable, m_en, irq, exp_irq);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        done_p = 0; ss_p = 0; txo_p = 0; txu_p = 0; rxo_p = 0; rxu_p = 0; ce_p = 0;
        tx_clr = 0; rx_clr = 0; sts_wr = 0; en_wr = 0; wr_data = '0;
    endtask

    task automatic expect_bit(string r, int b, logic v);
        vectors++;
        if (status[b] !== v) begin
            fails++;
            $display("FAIL %s status[%0d]=%b expected %b", r, b, status[b], v);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            fails++;
            $display("FAIL watchdog expired in %s", req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int lv[10] = '{0, 1, 15, 16, 17, 31, 32, 48, 63, 64};
        #1;
        req = "R1";
        check_all();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        tick();

        req = "R2";
        foreach (lv[i]) begin rx_used = CW'(lv[i]); tick(); end
        req = "R3";
        foreach (lv[i]) begin tx_used = CW'(lv[i]); tick(); end

        // R4: write ones to level bits; they must stay
        req = "R4";
        rx_used = CW'(64); tx_used = CW'(0);
        tick();
        sts_wr = 1; wr_data = 32'h0000_1F1F;
        tick();
        idle();
        tick();
        expect_bit("R4", 2, 1'b1);
        expect_bit("R4", 8, 1'b1);

        req = "R5";
        done_p = 1; ss_p = 1; txo_p = 1; txu_p = 1; rxo_p = 1; rxu_p = 1;
        tick();
        idle();
        tick(); tick();
        expect_bit("R5", 16, 1'b1);
        expect_bit("R5", 5, 1'b1);

        req = "R6";
        sts_wr = 1; wr_data = 32'h0001_0000;
        tick();
        idle();
        expect_bit("R6", 16, 1'b0);
        sts_wr = 1; wr_data = 32'h0002_0000; ss_p = 1;
        tick();
        idle();
        expect_bit("R6", 17, 1'b1);
        sts_wr = 1; wr_data = 32'hFFFF_FFFF;
        tick();
        idle();
        tick();

        req = "R7";
        ce_p = 1;
        tick();
        idle();
        sts_wr = 1; wr_data = 32'hFFFF_FFFF;
        tick();
        idle();
        tick();
        expect_bit("R7", 31, 1'b1);

        req = "R8";
        tx_used = CW'(64);
        tick();
        txo_p = 1; tx_clr = 1;
        tick();
        idle();
        expect_bit("R8", 13, 1'b0);
        expect_bit("R8", 8, 1'b1);
        tick();

        req = "R9";
        rx_used = CW'(50); rxu_p = 1;
        tick();
        idle();
        rx_clr = 1; rxo_p = 1;
        tick();
        idle();
        expect_bit("R9", 0, 1'b0);
        expect_bit("R9", 6, 1'b0);
        tick();

        req = "R10";
        en_wr = 1; wr_data = 32'hFFFF_FFFF;
        tick();
        idle();
        vectors++;
        if (enable !== 32'h0003_7F7F) begin
            fails++;
            $display("FAIL R10 enable=%h expected 00037f7f", enable);
        end

        req = "R11";
        en_wr = 1; wr_data = 32'h0001_0000;
        sts_wr = 1;
        tick();
        idle();
        done_p = 1;
        tick();
        idle();
        tick();
        en_wr = 1; wr_data = 32'h0;
        tick();
        idle();
        tick();

        req = "R12";
        vectors++;
        if ((status & ~32'h8003_7F7F) !== 32'h0) begin
            fails++;
            $display("FAIL R12 status=%h expected no bits outside mask", status);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule